// File: doc/BRIEF.md
# Interrupt Group Modifier Register Bank

This block stores one group-modifier bit for each extended shared interrupt. The bits are packed 32 to a word and reached over a simple register bus. Each interrupt's stored modifier bit is paired with a group-status bit that arrives from outside the block. The pair is decoded into a 2-bit interrupt group, which is presented on a registered output vector for use by later distribution logic.

Every bus access carries a security attribute. Whether an access may see or change a bit depends on that attribute, on the global security-disable control, and on the security class of the interrupt: the class is secure when the decoded group is one of the two secure groups. A feature-present strap turns the whole bank off. An affinity-routing enable turns the modifier bits into reserved zeros without losing the values already stored.

Top module: `grp_mod_bank`

## Requirements
- R1: Word n (0 ≤ n < NUM_IRQ/32) sits at byte address BASE_OFF + 4*n, with BASE_OFF = 0x3400 by default. Interrupt k (relative index) is bit k%32 of word k/32. An address outside the bank, or one with non-zero low two bits, reads as zero and writes to it are ignored.
- R2: After reset every stored bit is 0, bus_rdata is 0 and irq_group is 0.
- R3: While ext_present is 0, every read returns zero and writes are ignored. Stored values are kept and become visible again when the strap returns to 1.
- R4: Field irq_group[2k+1:2k] is decoded from {modifier, status} as follows: 00 gives 2'b00 (secure group 0), 01 gives 2'b01 (non-secure group 1), 10 gives 2'b10 (secure group 1), and 11 gives 2'b01.
- R5: An interrupt is secure when its decoded group is 00 or 10. When sec_disable is 0, a non-secure access reads secure interrupts' bits as zero and its writes to those bits are ignored. A secure access reads and writes every bit.
- R6: When sec_disable is 1, a non-secure access reads and writes every bit.
- R7: While aff_route_en is 0, the modifier bits read as zero, writes to them are ignored, and the decode treats every modifier as 0. The stored values are kept.
- R8: bus_rdata carries the addressed word in the cycle after bus_rd is high, and is zero after a cycle with no read. A read in the same cycle as a write returns the value held before the write.
- R9: A write changes only the permitted bits of the addressed word. All other bits keep their values.
- R10: irq_group reflects a change in status or modifier one clock after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_secure | input | 1 | 1 = secure access |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| sec_disable | input | 1 | Global security disable |
| ext_present | input | 1 | Extended-interrupt feature strap |
| aff_route_en | input | 1 | Affinity routing enabled |
| grp_status | input | NUM_IRQ | Group-status bit per interrupt |
| irq_group | output | 2*NUM_IRQ | Registered decoded group per interrupt |

## Verification
A corrupted stored modifier bit shows up on the next secure read of its word. It also reaches the decoded group field of that interrupt one clock after it happens, unless the interrupt's status bit is 1, because that folds both encodings onto non-secure group 1. A faulty permission mask shows as a non-secure read that exposes secure bits, or as a secure readback that differs after a filtered write. Both are visible within two cycles of the write. Errors in the strap or routing gating appear on the first read after the control toggles back.

// File: rtl/grp_mod_bank.sv
module grp_mod_bank #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_OFF = 'h3400
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic                  bus_secure,
  output logic [31:0]           bus_rdata,
  input  logic                  sec_disable,
  input  logic                  ext_present,
  input  logic                  aff_route_en,
  input  logic [NUM_IRQ-1:0]    grp_status,
  output logic [2*NUM_IRQ-1:0]  irq_group
);
  localparam int NUM_REGS = NUM_IRQ / 32;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * NUM_REGS);

  logic [NUM_IRQ-1:0]   mod_q;
  logic [NUM_IRQ-1:0]   eff_mod;
  logic [NUM_IRQ-1:0]   allow;
  logic [NUM_IRQ-1:0]   wmask;
  logic [2*NUM_IRQ-1:0] grp_d;
  logic [31:0]          vis_word [NUM_REGS];
  logic [ADDR_W-1:0]    off;
  logic [IDX_W-1:0]     idx;
  logic                 hit;
  logic                 live;

  assign off  = bus_addr - BASE_OFF;
  assign hit  = (bus_addr >= BASE_OFF) && (off < SPAN) && (off[1:0] == 2'b00);
  assign idx  = off[IDX_W+1:2];
  assign live = ext_present & aff_route_en;
  assign eff_mod = mod_q & {NUM_IRQ{live}};

  genvar i;
  generate
    for (i = 0; i < NUM_IRQ; i++) begin : g_bit
      assign grp_d[2*i +: 2] = grp_status[i] ? 2'b01 : {eff_mod[i], 1'b0};
      assign allow[i] = live & (bus_secure | sec_disable | grp_d[2*i]);
      assign wmask[i] = bus_wr & hit & (idx == IDX_W'(i / 32)) & allow[i];

      assert_group_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grp_status[i] |=> irq_group[2*i +: 2] == 2'b01);
      assert_ns_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && idx == IDX_W'(i / 32) && !bus_secure && !sec_disable && !grp_status[i])
        |=> $stable(mod_q[i]));
      assert_aff_off_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !aff_route_en |=> !irq_group[2*i+1]);
    end
    for (i = 0; i < NUM_REGS; i++) begin : g_word
      assign vis_word[i] = mod_q[32*i +: 32] & allow[32*i +: 32];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q     <= '0;
      bus_rdata <= '0;
      irq_group <= '0;
    end else begin
      mod_q     <= (mod_q & ~wmask) | ({NUM_REGS{bus_wdata}} & wmask);
      bus_rdata <= (bus_rd && hit) ? vis_word[idx] : 32'h0;
      irq_group <= grp_d;
    end
  end

  assert_reset_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (mod_q == '0 && bus_rdata == 32'h0));
  assert_strap_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_present |=> bus_rdata == 32'h0);
  assert_idle_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> bus_rdata == 32'h0);
  assert_outside_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit) |=> $stable(mod_q));
endmodule

// File: tb/grp_mod_bank_tb.sv
module grp_mod_bank_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_wr = 0, bus_rd = 0, bus_secure = 0;
  logic [31:0] bus_rdata;
  logic sec_disable = 0, ext_present = 1, aff_route_en = 1;
  logic [63:0] grp_status = {32'hFFFF0000, 32'h0000FFFF};
  logic [127:0] irq_group;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  grp_mod_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_secure(bus_secure), .bus_rdata(bus_rdata),
    .sec_disable(sec_disable), .ext_present(ext_present), .aff_route_en(aff_route_en),
    .grp_status(grp_status), .irq_group(irq_group));

  // entry: {write secure, sec_disable, addr, wdata, secure readback expected}
  localparam logic [81:0] VEC [0:7] = '{
    {1'b1, 1'b0, 16'h3400, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {1'b0, 1'b0, 16'h3400, 32'h00000000, 32'hFFFF0000},
    {1'b0, 1'b1, 16'h3400, 32'h00000000, 32'h00000000},
    {1'b0, 1'b0, 16'h3404, 32'hA5A5A5A5, 32'hA5A50000},
    {1'b1, 1'b0, 16'h3404, 32'h12345678, 32'h12345678},
    {1'b1, 1'b0, 16'h3408, 32'hFFFFFFFF, 32'h00000000},
    {1'b1, 1'b0, 16'h3402, 32'hFFFFFFFF, 32'h00000000},
    {1'b0, 1'b0, 16'h3400, 32'h0000FFFF, 32'h0000FFFF}
  };

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit sec, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_secure = sec; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input bit sec, input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_secure = sec; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [127:0] decode(input logic [63:0] m, input logic [63:0] s);
    logic [127:0] g;
    for (int k = 0; k < 64; k++)
      g[2*k +: 2] = s[k] ? 2'b01 : (m[k] ? 2'b10 : 2'b00);
    return g;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R2 rdata in reset", {96'h0, bus_rdata}, 128'h0);
    check("R2 irq_group in reset", irq_group, 128'h0);
    rst_n = 1;
    rd(1, 16'h3400, d); check("R2 word0 after reset", {96'h0, d}, 128'h0);
    rd(1, 16'h3404, d); check("R2 word1 after reset", {96'h0, d}, 128'h0);

    for (int v = 0; v < 8; v++) begin
      sec_disable = VEC[v][80];
      wr(VEC[v][81], VEC[v][79:64], VEC[v][63:32]);
      sec_disable = 0;
      rd(1, VEC[v][79:64], d);
      check($sformatf("R1/R5/R6/R9 vector %0d", v), {96'h0, d}, {96'h0, VEC[v][31:0]});
    end
    rd(1, 16'h3400, d); check("R1 misaligned write left word0", {96'h0, d}, {96'h0, 32'h0000FFFF});

    rd(0, 16'h3400, d); check("R5 ns read word0", {96'h0, d}, {96'h0, 32'h0000FFFF});
    rd(0, 16'h3404, d); check("R5 ns read word1 hides secure", {96'h0, d}, {96'h0, 32'h12340000});
    sec_disable = 1;
    rd(0, 16'h3404, d); check("R6 ns read with disable", {96'h0, d}, {96'h0, 32'h12345678});
    sec_disable = 0;

    @(negedge clk);
    check("R4 decode all four encodings", irq_group,
          decode({32'h12345678, 32'h0000FFFF}, grp_status));

    @(negedge clk);
    grp_status[32] = 1'b1;
    check("R10 group before edge", {126'h0, irq_group[65:64]}, 128'h0);
    @(negedge clk);
    check("R10 group one edge later", {126'h0, irq_group[65:64]}, 128'h1);
    grp_status[32] = 1'b0;

    aff_route_en = 0;
    rd(1, 16'h3404, d); check("R7 read zero when routing off", {96'h0, d}, 128'h0);
    check("R7 decode ignores modifier", irq_group, decode(64'h0, grp_status));
    wr(1, 16'h3404, 32'hFFFFFFFF);
    aff_route_en = 1;
    rd(1, 16'h3404, d); check("R7 write ignored, value kept", {96'h0, d}, {96'h0, 32'h12345678});

    ext_present = 0;
    rd(1, 16'h3400, d); check("R3 read zero when strap off", {96'h0, d}, 128'h0);
    wr(1, 16'h3400, 32'hFFFF0000);
    ext_present = 1;
    rd(1, 16'h3400, d); check("R3 write ignored, value kept", {96'h0, d}, {96'h0, 32'h0000FFFF});

    @(negedge clk);
    bus_wr = 1; bus_rd = 1; bus_secure = 1; bus_addr = 16'h3400; bus_wdata = 32'hAAAA5555;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    check("R8 read during write returns old", {96'h0, bus_rdata}, {96'h0, 32'h0000FFFF});
    @(negedge clk);
    check("R8 rdata zero without read", {96'h0, bus_rdata}, 128'h0);
    rd(1, 16'h3400, d); check("R8 new value after write", {96'h0, d}, {96'h0, 32'hAAAA5555});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule